// File: doc/BRIEF.md
# Operator Console Command Gate

This block sits behind the console character parser. It receives an operator command whose mnemonic has already been split off as three ASCII characters, together with one hexadecimal operand word. It then decides whether the command may run at this moment. A command that may run produces a single-cycle strobe on the line for its action and an echo pulse that carries the command index and the operand. A command that may not run produces a reject pulse with a reason. A mnemonic that is not recognised produces an illegal-command pulse.

Each command has its own gating rule. The rules depend on the panel functions switch and on whether the processor is idle. The block also holds the state of the interrupt level assigned to the console. A console interrupt command advances that level only when it is armed, and in that case the block pulses a trigger toward the interrupt system. The rest of the interrupt system sets the level state through a write port.

Top module: `console_cmd_gate`

## Requirements
- R1: During and right after reset, every output pulse is low and the console level state reads 00 (Disarmed). The state codes are 00 Disarmed, 01 Armed, 10 Waiting and 11 Active.
- R2: The mnemonics map to command indices and to the strobe bit with the same number: "I  "=0 (interrupt), "SSW"=1 (read switches), "SS "=2 (set switches), "LDN"=3, "RSY"=4, "RBP"=5, "RIO"=6, "HLT"=7, "RUN"=8. The first character sits in cmd_mnem[23:16].
- R3: Commands 0, 1 and 2 are accepted at every setting of panel_enable and sys_idle.
- R4: Commands 3, 4, 5, 6 and 8 are accepted only when panel_enable=1 and sys_idle=1.
- R5: Command 7 is accepted whenever panel_enable=1, whatever sys_idle is.
- R6: A command that fails its gating rule raises reject_valid with no strobe and no echo. reject_reason is 1 when the panel switch is disabled, which takes precedence, and 2 when the processor is not idle.
- R7: An unrecognised mnemonic raises illegal_cmd only. There is no strobe, no echo and no reject.
- R8: An accepted command raises exactly one strobe bit and echo_valid for exactly one cycle, one clock after cmd_valid. echo_code equals the command index and act_arg equals cmd_arg.
- R9: An accepted interrupt command moves the level from Armed (01) to Waiting (10) and pulses irq_trig in the same cycle as the state change.
- R10: An interrupt command leaves a Disarmed, Waiting or Active level unchanged and does not pulse irq_trig. Its strobe still fires.
- R11: lvl_set_valid loads lvl_set_code into the level state one clock later. If it arrives together with an interrupt command, the write wins and irq_trig stays low.
- R12: With cmd_valid low, no strobe, echo, reject or illegal pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A parsed command is present this cycle |
| cmd_mnem | input | 24 | Three ASCII mnemonic characters, first in the top byte |
| cmd_arg | input | ARG_W | Hexadecimal operand word |
| panel_enable | input | 1 | Panel functions switch is in its enable position |
| sys_idle | input | 1 | Processor is idle |
| lvl_set_valid | input | 1 | Write to the console level state |
| lvl_set_code | input | 2 | New level state code |
| act_strobe | output | 9 | One-hot action strobe, bit number = command index |
| act_arg | output | ARG_W | Operand of the accepted command |
| echo_valid | output | 1 | Accepted-command echo pulse |
| echo_code | output | 4 | Index of the accepted command |
| reject_valid | output | 1 | Command refused by its gating rule |
| reject_reason | output | 2 | 1 = switch disabled, 2 = not idle |
| illegal_cmd | output | 1 | Unknown mnemonic |
| irq_trig | output | 1 | Console level advanced from Armed to Waiting |
| lvl_state | output | 2 | Console level state code |

## Verification
The bench sweeps every known mnemonic plus several near-miss and lowercase ones across all four combinations of panel switch and idle. This separates the always-open commands, the commands that need both switch and idle, and halt, which needs the switch alone. The same sweep shows that the switch reason takes precedence over the idle reason. The console interrupt is issued from each of the four level states, which tells the single advancing transition apart from the three states it must leave alone. A collision case puts a level write in the same cycle as an interrupt.

// File: rtl/console_cmd_pkg.sv
package console_cmd_pkg;

    localparam int NUM_CMDS = 9;
    localparam int IDX_W    = 4;
    localparam int MNEM_W   = 24;

    typedef enum logic [1:0] {
        LVL_DISARMED = 2'b00,
        LVL_ARMED    = 2'b01,
        LVL_WAITING  = 2'b10,
        LVL_ACTIVE   = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_SWITCH  = 2'd1,
        RSN_NOTIDLE = 2'd2
    } reason_e;

    localparam logic [IDX_W-1:0] IDX_INT = 4'd0;

    localparam logic [MNEM_W-1:0] MNEM_TBL [NUM_CMDS] = '{
        "I  ", "SSW", "SS ", "LDN", "RSY", "RBP", "RIO", "HLT", "RUN"
    };

    // bit i set: command i needs the panel switch / the idle processor
    localparam logic [NUM_CMDS-1:0] NEED_EN   = 9'b1_1111_1000;
    localparam logic [NUM_CMDS-1:0] NEED_IDLE = 9'b1_0111_1000;

endpackage

// File: rtl/ccg_decode.sv
module ccg_decode
    import console_cmd_pkg::*;
(
    input  logic [MNEM_W-1:0] mnem,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_CMDS; i++) begin
            if (mnem == MNEM_TBL[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ccg_policy.sv
module ccg_policy
    import console_cmd_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             panel_enable,
    input  logic             sys_idle,
    output logic             allow,
    output reason_e          reason
);
    logic need_en, need_idle;

    always_comb begin
        need_en   = NEED_EN[idx];
        need_idle = NEED_IDLE[idx];
        if (need_en && !panel_enable)
            reason = RSN_SWITCH;
        else if (need_idle && !sys_idle)
            reason = RSN_NOTIDLE;
        else
            reason = RSN_NONE;
        allow = (reason == RSN_NONE);
    end
endmodule

// File: rtl/ccg_irq_level.sv
module ccg_irq_level
    import console_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       set_valid,
    input  logic [1:0] set_code,
    output logic [1:0] state,
    output logic       trig
);
    typedef struct packed {
        lvl_e lvl;
        logic trig;
    } lvl_reg_t;

    lvl_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.trig = 1'b0;
        if (set_valid) begin
            r_d.lvl = lvl_e'(set_code);
        end else if (fire && r_q.lvl == LVL_ARMED) begin
            r_d.lvl  = LVL_WAITING;
            r_d.trig = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{lvl: LVL_DISARMED, trig: 1'b0};
        else        r_q <= r_d;
    end

    assign state = r_q.lvl;
    assign trig  = r_q.trig;

    AST_TRIG_LANDS_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> state == LVL_WAITING); // R9
    AST_TRIG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(state) == LVL_ARMED); // R9
    AST_NO_TRIG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_valid) |-> !trig); // R11
endmodule

// File: rtl/console_cmd_gate.sv
module console_cmd_gate
    import console_cmd_pkg::*;
#(
    parameter int ARG_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [MNEM_W-1:0]   cmd_mnem,
    input  logic [ARG_W-1:0]    cmd_arg,
    input  logic                panel_enable,
    input  logic                sys_idle,
    input  logic                lvl_set_valid,
    input  logic [1:0]          lvl_set_code,
    output logic [NUM_CMDS-1:0] act_strobe,
    output logic [ARG_W-1:0]    act_arg,
    output logic                echo_valid,
    output logic [IDX_W-1:0]    echo_code,
    output logic                reject_valid,
    output logic [1:0]          reject_reason,
    output logic                illegal_cmd,
    output logic                irq_trig,
    output logic [1:0]          lvl_state
);
    typedef struct packed {
        logic [NUM_CMDS-1:0] strobe;
        logic [ARG_W-1:0]    arg;
        logic                echo;
        logic [IDX_W-1:0]    code;
        logic                rej;
        logic [1:0]          rsn;
        logic                ill;
    } out_reg_t;

    out_reg_t o_d, o_q;

    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             pol_allow;
    reason_e          pol_reason;
    logic             int_fire;

    ccg_decode u_decode (
        .mnem (cmd_mnem),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    ccg_policy u_policy (
        .idx          (dec_idx),
        .panel_enable (panel_enable),
        .sys_idle     (sys_idle),
        .allow        (pol_allow),
        .reason       (pol_reason)
    );

    assign int_fire = cmd_valid && dec_hit && pol_allow && (dec_idx == IDX_INT);

    ccg_irq_level u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (int_fire),
        .set_valid (lvl_set_valid),
        .set_code  (lvl_set_code),
        .state     (lvl_state),
        .trig      (irq_trig)
    );

    always_comb begin
        o_d     = '0;
        o_d.arg = o_q.arg;
        if (cmd_valid) begin
            if (!dec_hit) begin
                o_d.ill = 1'b1;
            end else if (!pol_allow) begin
                o_d.rej = 1'b1;
                o_d.rsn = pol_reason;
            end else begin
                o_d.strobe[dec_idx] = 1'b1;
                o_d.echo            = 1'b1;
                o_d.code            = dec_idx;
                o_d.arg             = cmd_arg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign act_strobe    = o_q.strobe;
    assign act_arg       = o_q.arg;
    assign echo_valid    = o_q.echo;
    assign echo_code     = o_q.code;
    assign reject_valid  = o_q.rej;
    assign reject_reason = o_q.rsn;
    assign illegal_cmd   = o_q.ill;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_strobe)); // R8
    AST_ECHO_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        echo_valid == (act_strobe != '0)); // R8
    AST_OUTCOMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({echo_valid, reject_valid, illegal_cmd}) <= 1); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> !(echo_valid || reject_valid || illegal_cmd)); // R12
    AST_HALT_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        act_strobe[7] |-> $past(panel_enable)); // R5
    AST_RUN_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        act_strobe[8] |-> $past(panel_enable && sys_idle)); // R4
    AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> (reject_reason == 2'd1 || reject_reason == 2'd2)); // R6
endmodule

// File: tb/console_cmd_gate_tb_top.sv
module console_cmd_gate_tb_top;
    localparam int ARG_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [23:0]       cmd_mnem = '0;
    logic [ARG_W-1:0]  cmd_arg = '0;
    logic              panel_enable = 1'b0;
    logic              sys_idle = 1'b0;
    logic              lvl_set_valid = 1'b0;
    logic [1:0]        lvl_set_code = '0;
    logic [8:0]        act_strobe;
    logic [ARG_W-1:0]  act_arg;
    logic              echo_valid;
    logic [3:0]        echo_code;
    logic              reject_valid;
    logic [1:0]        reject_reason;
    logic              illegal_cmd;
    logic              irq_trig;
    logic [1:0]        lvl_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    console_cmd_gate #(.ARG_W(ARG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mnem(cmd_mnem),
        .cmd_arg(cmd_arg), .panel_enable(panel_enable), .sys_idle(sys_idle),
        .lvl_set_valid(lvl_set_valid), .lvl_set_code(lvl_set_code),
        .act_strobe(act_strobe), .act_arg(act_arg), .echo_valid(echo_valid),
        .echo_code(echo_code), .reject_valid(reject_valid),
        .reject_reason(reject_reason), .illegal_cmd(illegal_cmd),
        .irq_trig(irq_trig), .lvl_state(lvl_state)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one command: drive at negedge, sample 1ns after the registering edge
    task automatic issue(input logic [23:0] m, input logic [ARG_W-1:0] a,
                         input logic en, input logic idl);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mnem = m; cmd_arg = a;
        panel_enable = en; sys_idle = idl;
        @(posedge clk); #1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_level(input logic [1:0] c);
        @(negedge clk);
        lvl_set_valid = 1'b1; lvl_set_code = c;
        @(negedge clk);
        lvl_set_valid = 1'b0;
    endtask

    function automatic logic [23:0] mnem_of(input int i);
        case (i)
            0: return "I  "; 1: return "SSW"; 2: return "SS ";
            3: return "LDN"; 4: return "RSY"; 5: return "RBP";
            6: return "RIO"; 7: return "HLT"; 8: return "RUN";
            9: return "XYZ"; 10: return "SSX"; 11: return "run";
            default: return 24'h0;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "strobe in reset", 32'(act_strobe), 0);
        chk("R1", "level in reset", 32'(lvl_state), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "outputs after reset",
            32'({act_strobe, echo_valid, reject_valid, illegal_cmd, irq_trig}), 0);
        chk("R1", "level after reset", 32'(lvl_state), 0);

        // R12: idle cycles with inputs wiggling but cmd_valid low
        @(negedge clk); cmd_mnem = "RUN"; panel_enable = 1; sys_idle = 1;
        @(posedge clk); #1;
        chk("R12", "quiet without valid",
            32'({act_strobe, echo_valid, reject_valid, illegal_cmd}), 0);

        // sweep every mnemonic over all switch/idle combinations
        for (int c = 0; c < 13; c++) begin
            for (int e = 0; e < 2; e++) begin
                for (int d = 0; d < 2; d++) begin
                    logic known, need_en, need_idle, acc;
                    logic [1:0] rsn;
                    logic [ARG_W-1:0] a;
                    string rq;
                    a = ARG_W'(16'hA000 + c * 16 + e * 2 + d);
                    known = (c < 9);
                    need_en = (c >= 3);
                    need_idle = (c >= 3) && (c != 7);
                    rsn = (need_en && !e) ? 2'd1 : (need_idle && !d) ? 2'd2 : 2'd0;
                    acc = known && (rsn == 0);
                    rq = !known ? "R7" : (c < 3) ? "R3" : (c == 7) ? "R5" : "R4";
                    @(negedge clk);
                    cmd_valid = 1'b1; cmd_mnem = mnem_of(c); cmd_arg = a;
                    panel_enable = e[0]; sys_idle = d[0];
                    @(posedge clk); #1;
                    chk(rq, "strobe", 32'(act_strobe), acc ? (32'd1 << c) : 0);
                    chk("R8", "echo", 32'(echo_valid), 32'(acc));
                    if (acc) begin
                        chk("R2", "echo code", 32'(echo_code), 32'(c));
                        chk("R8", "arg", 32'(act_arg), 32'(a));
                    end
                    chk("R6", "reject", 32'(reject_valid), 32'(known && !acc));
                    if (known && !acc)
                        chk("R6", "reason", 32'(reject_reason), 32'(rsn));
                    chk("R7", "illegal", 32'(illegal_cmd), 32'(!known));
                    @(negedge clk); cmd_valid = 1'b0;
                    @(posedge clk); #1;
                    chk("R8", "single cycle",
                        32'({act_strobe, echo_valid, reject_valid, illegal_cmd}), 0);
                end
            end
        end

        // console interrupt from each level state, with switch off and busy
        for (int s = 0; s < 4; s++) begin
            set_level(2'(s));
            @(posedge clk); #1;
            chk("R11", "level write", 32'(lvl_state), 32'(s));
            @(negedge clk);
            cmd_valid = 1'b1; cmd_mnem = "I  "; panel_enable = 0; sys_idle = 0;
            @(posedge clk); #1;
            chk(s == 1 ? "R9" : "R10", "level after int", 32'(lvl_state), s == 1 ? 2 : s);
            chk(s == 1 ? "R9" : "R10", "irq trig", 32'(irq_trig), 32'(s == 1));
            chk("R10", "int strobe", 32'(act_strobe), 1);
            @(negedge clk); cmd_valid = 1'b0;
            @(posedge clk); #1;
            chk("R9", "trig one cycle", 32'(irq_trig), 0);
        end

        // collision: write to Active together with interrupt while Armed
        set_level(2'd1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mnem = "I  ";
        lvl_set_valid = 1'b1; lvl_set_code = 2'd3;
        @(posedge clk); #1;
        chk("R11", "write wins", 32'(lvl_state), 3);
        chk("R11", "no trig on collision", 32'(irq_trig), 0);
        chk("R11", "strobe on collision", 32'(act_strobe), 1);
        @(negedge clk); cmd_valid = 1'b0; lvl_set_valid = 1'b0;

        // rejected interrupt never happens; illegal one must not touch level
        set_level(2'd1);
        issue("IX ", 16'h0, 1, 1);
        @(posedge clk); #1;
        chk("R7", "illegal leaves level", 32'(lvl_state), 1);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule